// File: doc/BRIEF.md
# Dual-Channel Input De-Skew FIFO

Two sample streams enter this block, each paced by its own source clock. Both source clocks run at the same nominal rate, but the phase between them is unknown when the system powers up. It also wanders as temperature and cable delay change. A receiver further down the line needs both channels to share one clock edge with one setup relationship. This block gives it that by writing each stream into its own asynchronous FIFO, using that stream's own clock. Both FIFOs are then drained together by a single read clock. A static select input takes that read clock from either channel's source clock.

Reading starts only when each FIFO holds at least half its depth. From then on, one word leaves each FIFO on every read cycle. The two outputs therefore carry the same sample index, and the buffered slack absorbs phase wander in either direction. A FIFO that runs dry while draining, or a write that arrives at a full FIFO, is an error. It sets a sticky error flag and triggers a flush of both FIFOs. The block then refills to the half-way threshold before it resumes output.

Top module: `deskew_pair`

## Requirements
- R1: After reset, `out_valid` and `err` are low and both FIFOs are empty.
- R2: `out_valid` does not rise until both FIFOs have been seen holding at least DEPTH/2 words each. Once both reach that level, output starts without further input.
- R3: On every cycle with `out_valid` high, `out_a` and `out_b` hold words written with the same sample index on their channels. This holds for any fixed phase between the source clocks and while that phase drifts.
- R4: While draining, exactly one word leaves each FIFO per read clock cycle. Each write order is kept, so a counting input appears on the output as a count incrementing by one every read cycle (modulo 2^DW).
- R5: The first word presented after a start is the first word written after the last reset or flush. No word is lost at start-up.
- R6: If either FIFO is empty on a read cycle while draining, `err` is set and `out_valid` is low from that same registered cycle on.
- R7: A write into a full FIFO is dropped, and it sets `err` even before draining has begun.
- R8: `err` stays high until reset. After any error, both FIFOs are flushed for FLUSH_CYC read cycles and then refilled. Streams that restart together with equal indices come out aligned again.
- R9: The read clock is `clk_a` when `sel_b` is 0 and `clk_b` when `sel_b` is 1. `sel_b` changes only while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| sel_b | input | 1 | Read clock choice: 0 selects clk_a, 1 selects clk_b |
| clk_a | input | 1 | Source clock of channel A |
| wr_en_a | input | 1 | Channel A word strobe, sampled on clk_a |
| wr_data_a | input | DW | Channel A sample |
| clk_b | input | 1 | Source clock of channel B |
| wr_en_b | input | 1 | Channel B word strobe, sampled on clk_b |
| wr_data_b | input | DW | Channel B sample |
| out_a | output | DW | Aligned channel A sample, read clock domain |
| out_b | output | DW | Aligned channel B sample, read clock domain |
| out_valid | output | 1 | Both outputs carry a fresh aligned pair |
| err | output | 1 | Sticky overflow or underflow indication |

## Verification
Error detection and the start decision share one controller cycle. An overflow pulse from channel A can arrive while the fill check is also evaluating the two levels. The bench forces this by filling A past full while B stays idle, and it judges the outcome at the ports: `err` must rise and `out_valid` must never rise. The same collision occurs during draining when one FIFO runs dry in the cycle a pop would have happened. That case is provoked by stopping one channel alone and is judged by `err` rising together with `out_valid` falling. After each error the bench restarts both channels with a fresh common index and expects aligned output carrying that index.

// File: rtl/dsk_pkg.sv
`timescale 1ns/1ps
package dsk_pkg;
    // Controller phases of the shared read side.
    typedef enum logic [1:0] {
        ST_FILL  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FLUSH = 2'd2
    } dsk_state_e;

    localparam int unsigned NUM_CH = 2;
endpackage

// File: rtl/dsk_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer for a vector whose value changes one bit at a time.
module dsk_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.s2;
endmodule

// File: rtl/dsk_fifo_wr.sv
`timescale 1ns/1ps
// Write half of one channel FIFO: storage, write pointer, full test, overflow toggle.
module dsk_fifo_wr #(
    parameter int DW = 16,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic [AW:0]   rd_gray_s,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic [AW:0]   wr_gray,
    output logic          ovf_tgl
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          tgl;
    } wr_t;

    wr_t         st_d, st_q;
    logic        full;
    logic        wr_ok;
    logic [DW-1:0] mem [DEPTH];

    // Full when the write pointer is one lap ahead of the synchronized read pointer.
    assign full  = (st_q.gray == {~rd_gray_s[PW-1:PW-2], rd_gray_s[PW-3:0]});
    assign wr_ok = wr_en && !full;

    always_comb begin
        st_d = st_q;
        if (wr_ok) begin
            st_d.bin  = st_q.bin + 1'b1;
            st_d.gray = st_d.bin ^ (st_d.bin >> 1);
        end
        if (wr_en && full) begin
            st_d.tgl = ~st_q.tgl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem[st_q.bin[AW-1:0]] <= wr_data;
    end

    assign rd_data = mem[rd_addr];
    assign wr_gray = st_q.gray;
    assign ovf_tgl = st_q.tgl;
endmodule

// File: rtl/dsk_fifo_rd.sv
`timescale 1ns/1ps
// Read half of one channel FIFO: read pointer, empty test, fill level, snap-to-write flush.
module dsk_fifo_rd #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW:0]   wr_gray_s,
    input  logic          pop,
    input  logic          snap,
    output logic [AW-1:0] rd_addr,
    output logic [AW:0]   rd_gray,
    output logic          empty,
    output logic [AW:0]   level
);
    localparam int PW = AW + 1;

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
    } rd_t;

    rd_t           st_d, st_q;
    logic [PW-1:0] wbin;

    always_comb begin
        for (int i = 0; i < PW; i++) begin
            wbin[i] = ^(wr_gray_s >> i);
        end
    end

    assign empty = (st_q.gray == wr_gray_s);
    assign level = wbin - st_q.bin;

    always_comb begin
        st_d = st_q;
        if (snap) begin
            st_d.bin = wbin;
        end else if (pop && !empty) begin
            st_d.bin = st_q.bin + 1'b1;
        end
        st_d.gray = st_d.bin ^ (st_d.bin >> 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_addr = st_q.bin[AW-1:0];
    assign rd_gray = st_q.gray;
endmodule

// File: rtl/dsk_fifo.sv
`timescale 1ns/1ps
// One channel's clock-crossing FIFO with overflow event brought into the read domain.
module dsk_fifo #(
    parameter int DW = 16,
    parameter int AW = 4
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          pop,
    input  logic          snap,
    output logic [DW-1:0] rd_data,
    output logic          empty,
    output logic [AW:0]   level,
    output logic          ovf_pulse
);
    localparam int PW = AW + 1;

    logic [PW-1:0] wr_gray, wr_gray_s;
    logic [PW-1:0] rd_gray, rd_gray_s;
    logic [AW-1:0] rd_addr;
    logic          ovf_tgl, ovf_tgl_s;
    logic          ovf_seen_d, ovf_seen_q;

    dsk_fifo_wr #(.DW(DW), .AW(AW)) u_wr (
        .clk       (wr_clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_gray_s (rd_gray_s),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .wr_gray   (wr_gray),
        .ovf_tgl   (ovf_tgl)
    );

    dsk_sync #(.W(PW)) u_sync_rd2wr (
        .clk (wr_clk), .rst_n (rst_n), .din (rd_gray), .dout (rd_gray_s)
    );

    dsk_sync #(.W(PW)) u_sync_wr2rd (
        .clk (rd_clk), .rst_n (rst_n), .din (wr_gray), .dout (wr_gray_s)
    );

    dsk_sync #(.W(1)) u_sync_ovf (
        .clk (rd_clk), .rst_n (rst_n), .din (ovf_tgl), .dout (ovf_tgl_s)
    );

    dsk_fifo_rd #(.AW(AW)) u_rd (
        .clk       (rd_clk),
        .rst_n     (rst_n),
        .wr_gray_s (wr_gray_s),
        .pop       (pop),
        .snap      (snap),
        .rd_addr   (rd_addr),
        .rd_gray   (rd_gray),
        .empty     (empty),
        .level     (level)
    );

    always_comb begin
        ovf_seen_d = ovf_tgl_s;
    end

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) ovf_seen_q <= 1'b0;
        else        ovf_seen_q <= ovf_seen_d;
    end

    assign ovf_pulse = ovf_tgl_s ^ ovf_seen_q;
endmodule

// File: rtl/dsk_ctrl.sv
`timescale 1ns/1ps
// Shared read-side controller: start threshold, lockstep pops, error and flush.
module dsk_ctrl
    import dsk_pkg::*;
#(
    parameter int DW        = 16,
    parameter int AW        = 4,
    parameter int FLUSH_CYC = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            empty,
    input  logic [1:0][AW:0]      level,
    input  logic [1:0]            ovf,
    input  logic [1:0][DW-1:0]    rdata,
    output logic                  pop,
    output logic                  snap,
    output logic                  running,
    output logic [DW-1:0]         out_a,
    output logic [DW-1:0]         out_b,
    output logic                  out_valid,
    output logic                  err
);
    localparam int            PW       = AW + 1;
    localparam int            CW       = $clog2(FLUSH_CYC);
    localparam logic [PW-1:0] HALF_LVL = PW'((1 << AW) / 2);
    localparam logic [CW-1:0] CNT_LAST = CW'(FLUSH_CYC - 1);

    typedef struct packed {
        dsk_state_e          state;
        logic [CW-1:0]       cnt;
        logic                err;
        logic                ovalid;
        logic [1:0][DW-1:0]  odata;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  ovf_any;
    logic  both_ready;
    logic  half_met;

    assign ovf_any    = |ovf;
    assign both_ready = (empty == 2'b00);
    assign half_met   = (level[0] >= HALF_LVL) && (level[1] >= HALF_LVL);

    always_comb begin
        st_d        = st_q;
        st_d.ovalid = 1'b0;
        pop         = 1'b0;
        snap        = 1'b0;
        unique case (st_q.state)
            ST_FILL: begin
                if (ovf_any) begin
                    st_d.err   = 1'b1;
                    st_d.state = ST_FLUSH;
                    st_d.cnt   = '0;
                end else if (half_met) begin
                    st_d.state = ST_RUN;
                end
            end
            ST_RUN: begin
                if (ovf_any || !both_ready) begin
                    st_d.err   = 1'b1;
                    st_d.state = ST_FLUSH;
                    st_d.cnt   = '0;
                end else begin
                    pop         = 1'b1;
                    st_d.ovalid = 1'b1;
                    st_d.odata  = rdata;
                end
            end
            ST_FLUSH: begin
                snap = 1'b1;
                if (st_q.cnt == CNT_LAST) begin
                    st_d.state = ST_FILL;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            default: st_d.state = ST_FILL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= ST_FILL;
        end else begin
            st_q <= st_d;
        end
    end

    assign running   = (st_q.state == ST_RUN);
    assign out_a     = st_q.odata[0];
    assign out_b     = st_q.odata[1];
    assign out_valid = st_q.ovalid;
    assign err       = st_q.err;
endmodule

// File: rtl/dsk_clk_sel.sv
`timescale 1ns/1ps
// Static read clock choice; the select is only changed while the block is in reset.
module dsk_clk_sel (
    input  logic sel_b,
    input  logic clk_a,
    input  logic clk_b,
    output logic clk_rd
);
    assign clk_rd = sel_b ? clk_b : clk_a;
endmodule

// File: rtl/deskew_pair.sv
`timescale 1ns/1ps
module deskew_pair #(
    parameter int DW        = 16,
    parameter int DEPTH     = 16,
    parameter int FLUSH_CYC = 8
) (
    input  logic          rst_n,
    input  logic          sel_b,
    input  logic          clk_a,
    input  logic          wr_en_a,
    input  logic [DW-1:0] wr_data_a,
    input  logic          clk_b,
    input  logic          wr_en_b,
    input  logic [DW-1:0] wr_data_b,
    output logic [DW-1:0] out_a,
    output logic [DW-1:0] out_b,
    output logic          out_valid,
    output logic          err
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic                clk_rd;
    logic [1:0]          wr_clk_v;
    logic [1:0]          wr_en_v;
    logic [1:0][DW-1:0]  wr_data_v;
    logic [1:0][DW-1:0]  rdata;
    logic [1:0]          empty;
    logic [1:0][PW-1:0]  level;
    logic [1:0]          ovf;
    logic                pop;
    logic                snap;
    logic                running;

    assign wr_clk_v  = {clk_b, clk_a};
    assign wr_en_v   = {wr_en_b, wr_en_a};
    assign wr_data_v = {wr_data_b, wr_data_a};

    dsk_clk_sel u_clk_sel (
        .sel_b  (sel_b),
        .clk_a  (clk_a),
        .clk_b  (clk_b),
        .clk_rd (clk_rd)
    );

    for (genvar ch = 0; ch < dsk_pkg::NUM_CH; ch++) begin : g_ch
        dsk_fifo #(.DW(DW), .AW(AW)) u_fifo (
            .wr_clk    (wr_clk_v[ch]),
            .rd_clk    (clk_rd),
            .rst_n     (rst_n),
            .wr_en     (wr_en_v[ch]),
            .wr_data   (wr_data_v[ch]),
            .pop       (pop),
            .snap      (snap),
            .rd_data   (rdata[ch]),
            .empty     (empty[ch]),
            .level     (level[ch]),
            .ovf_pulse (ovf[ch])
        );
    end

    dsk_ctrl #(.DW(DW), .AW(AW), .FLUSH_CYC(FLUSH_CYC)) u_ctrl (
        .clk       (clk_rd),
        .rst_n     (rst_n),
        .empty     (empty),
        .level     (level),
        .ovf       (ovf),
        .rdata     (rdata),
        .pop       (pop),
        .snap      (snap),
        .running   (running),
        .out_a     (out_a),
        .out_b     (out_b),
        .out_valid (out_valid),
        .err       (err)
    );
endmodule

// File: rtl/dsk_chk.sv
`timescale 1ns/1ps
module dsk_chk #(
    parameter int DEPTH = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       pop,
    input logic [1:0]                 empty,
    input logic [$clog2(DEPTH):0]     level_a,
    input logic [$clog2(DEPTH):0]     level_b,
    input logic [1:0]                 ovf,
    input logic                       running,
    input logic                       out_valid,
    input logic                       err
);
    localparam int PW = $clog2(DEPTH) + 1;
    localparam logic [PW-1:0] HALF_LVL = PW'(DEPTH / 2);

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    // R6
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (empty == 2'b00));

    // R3
    valid_had_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(empty == 2'b00));

    // R2
    start_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past((level_a >= HALF_LVL) && (level_b >= HALF_LVL)));

    // R7
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $past((ovf != 2'b00) || (running && (empty != 2'b00))));

    // R6
    underflow_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && (empty != 2'b00)) |=> !running);
endmodule

bind deskew_pair dsk_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk_rd),
    .rst_n     (rst_n),
    .pop       (pop),
    .empty     (empty),
    .level_a   (level[0]),
    .level_b   (level[1]),
    .ovf       (ovf),
    .running   (running),
    .out_valid (out_valid),
    .err       (err)
);

// File: tb/deskew_pair_tb_top.sv
`timescale 1ns/1ps
module deskew_pair_tb_top;
    localparam int DW    = 16;
    localparam int DEPTH = 16;
    localparam int HALF  = DEPTH / 2;

    // Vector: {sel_b, start phase of clk_b, drifted phase, first sample index}
    localparam int NV = 4;
    localparam logic [24:0] VEC [NV] = '{
        {1'b0, 4'd2, 4'd3, 16'h0100},
        {1'b1, 4'd3, 4'd2, 16'hA000},
        {1'b0, 4'd6, 4'd7, 16'hFFFC},
        {1'b1, 4'd7, 4'd6, 16'h1234}
    };

    logic          clk_a = 1'b0;
    logic          clk_b = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel_b = 1'b0;
    logic          wr_en_a = 1'b0, wr_en_b = 1'b0;
    logic [DW-1:0] wr_data_a = '0, wr_data_b = '0;
    logic [DW-1:0] out_a, out_b;
    logic          out_valid, err;

    int            phase_b = 2;
    bit            en_a = 1'b0, en_b = 1'b0;
    logic [DW-1:0] seed = '0;
    logic [DW-1:0] cnt_a = '0, cnt_b = '0;
    int            checks = 0, errors = 0;

    // 125 MHz source clocks; channel B is a phase-shifted copy of channel A.
    initial forever #4 clk_a = ~clk_a;
    always @(clk_a) clk_b <= #(phase_b) clk_a;

    always @(negedge clk_a) begin
        wr_en_a   <= en_a;
        wr_data_a <= cnt_a;
        cnt_a     <= en_a ? cnt_a + 1'b1 : seed;
    end

    always @(negedge clk_b) begin
        wr_en_b   <= en_b;
        wr_data_b <= cnt_b;
        cnt_b     <= en_b ? cnt_b + 1'b1 : seed;
    end

    deskew_pair #(.DW(DW), .DEPTH(DEPTH), .FLUSH_CYC(8)) dut_i (
        .rst_n     (rst_n),
        .sel_b     (sel_b),
        .clk_a     (clk_a),
        .wr_en_a   (wr_en_a),
        .wr_data_a (wr_data_a),
        .clk_b     (clk_b),
        .wr_en_b   (wr_en_b),
        .wr_data_b (wr_data_b),
        .out_a     (out_a),
        .out_b     (out_b),
        .out_valid (out_valid),
        .err       (err)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic rd_neg();
        if (sel_b) @(negedge clk_b);
        else       @(negedge clk_a);
    endtask

    task automatic do_reset(input bit s, input int ph);
        rst_n   = 1'b0;
        en_a    = 1'b0;
        en_b    = 1'b0;
        sel_b   = s;
        phase_b = ph;
        repeat (4) @(negedge clk_a);
        @(posedge clk_a);
        #1 rst_n = 1'b1;
        repeat (3) rd_neg();
    endtask

    task automatic wait_valid(output int n);
        n = 0;
        while (!out_valid && n < 80) begin
            rd_neg();
            n++;
        end
    endtask

    task automatic wait_err(output int n);
        n = 0;
        while (!err && n < 80) begin
            rd_neg();
            n++;
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int            n;
        bit            seen;
        logic [DW-1:0] prev, s0, s1, s2;

        // Table walk: aligned start and steady draining under several phases and clock choices.
        for (int v = 0; v < NV; v++) begin
            do_reset(VEC[v][24], int'(VEC[v][23:20]));
            chk("R1", "out_valid after reset", out_valid, 0);
            chk("R1", "err after reset", err, 0);
            seed = VEC[v][15:0];
            rd_neg();
            en_a = 1'b1;
            en_b = 1'b1;
            wait_valid(n);
            chk("R2", $sformatf("start needs half fill (waited %0d)", n), n >= HALF, 1);
            chk("R5", "first word A", out_a, VEC[v][15:0]);
            chk("R3", "first word B", out_b, VEC[v][15:0]);
            prev = out_a;
            for (int c = 0; c < 24; c++) begin
                if (c == 12) phase_b = int'(VEC[v][19:16]);
                rd_neg();
                chk("R4", "valid while draining", out_valid, 1);
                chk("R4", "next index A", out_a, DW'(prev + 1'b1));
                chk("R3", "B matches A", out_b, out_a);
                prev = out_a;
            end
            chk("R6", "no error in steady run", err, 0);
            en_a = 1'b0;
            en_b = 1'b0;
        end

        // R2: below threshold on B, nothing may come out.
        do_reset(1'b0, 3);
        seed = 16'h0000;
        rd_neg();
        en_a = 1'b1;
        en_b = 1'b1;
        repeat (5) rd_neg();
        en_b = 1'b0;
        repeat (7) rd_neg();
        en_a = 1'b0;
        seen = 1'b0;
        repeat (20) begin
            rd_neg();
            if (out_valid) seen = 1'b1;
        end
        chk("R2", "no output with B under half", seen, 0);
        chk("R2", "no error below threshold", err, 0);
        en_b = 1'b1;
        repeat (5) rd_neg();
        en_b = 1'b0;
        wait_valid(n);
        chk("R2", "output once both reach half", out_valid, 1);

        // R9: read clock selection observed on output update edges.
        for (int s = 0; s < 2; s++) begin
            do_reset(s[0], 3);
            seed = 16'h0500;
            rd_neg();
            en_a = 1'b1;
            en_b = 1'b1;
            wait_valid(n);
            repeat (3) rd_neg();
            @(negedge clk_a);
            s0 = out_a;
            @(posedge clk_a);
            #1 s1 = out_a;
            #3 s2 = out_a;
            if (s == 0) begin
                chk("R9", "clk_a edge updates output", s1, DW'(s0 + 1'b1));
                chk("R9", "clk_b edge leaves output", s2, s1);
            end else begin
                chk("R9", "clk_a edge leaves output", s1, s0);
                chk("R9", "clk_b edge updates output", s2, DW'(s1 + 1'b1));
            end
            en_a = 1'b0;
            en_b = 1'b0;
        end

        // R6 then R8: underflow by stopping A alone, then realignment.
        do_reset(1'b1, 6);
        seed = 16'h0040;
        rd_neg();
        en_a = 1'b1;
        en_b = 1'b1;
        wait_valid(n);
        repeat (5) rd_neg();
        en_a = 1'b0;
        wait_err(n);
        en_b = 1'b0;
        chk("R6", "underflow raises err", err, 1);
        chk("R6", "underflow drops out_valid", out_valid, 0);
        repeat (20) rd_neg();
        chk("R8", "err sticky after underflow", err, 1);
        chk("R8", "idle after flush", out_valid, 0);
        seed = 16'h2000;
        rd_neg();
        en_a = 1'b1;
        en_b = 1'b1;
        wait_valid(n);
        chk("R8", "realigned A after underflow", out_a, 16'h2000);
        chk("R8", "realigned B after underflow", out_b, 16'h2000);
        repeat (6) rd_neg();
        chk("R3", "still aligned after recovery", out_b, out_a);
        chk("R8", "err held during recovery", err, 1);
        en_a = 1'b0;
        en_b = 1'b0;

        // R7 then R8: overflow of A before draining ever starts.
        do_reset(1'b0, 2);
        seed = 16'h0000;
        rd_neg();
        en_a = 1'b1;
        seen = 1'b0;
        n = 0;
        while (!err && n < 80) begin
            rd_neg();
            if (out_valid) seen = 1'b1;
            n++;
        end
        en_a = 1'b0;
        chk("R7", "overflow raises err", err, 1);
        chk("R7", "no output during overflow", seen, 0);
        repeat (20) rd_neg();
        chk("R8", "err sticky after overflow", err, 1);
        seed = 16'h7000;
        rd_neg();
        en_a = 1'b1;
        en_b = 1'b1;
        wait_valid(n);
        chk("R8", "realigned A after overflow", out_a, 16'h7000);
        chk("R8", "realigned B after overflow", out_b, 16'h7000);
        en_a = 1'b0;
        en_b = 1'b0;

        finish_run();
    end
endmodule